// File: doc/BRIEF.md
# Receive Buffer Ring Fetcher

This block walks a circular table of receive-buffer descriptors kept in system memory. Each descriptor holds four 16-bit words: the low and high halves of a buffer's start address, then the low and high halves of that buffer's size in words. A fetch reads the four words at the current ring position, exposes the buffer address and word count to the receive engine, and steps the ring position forward.

A fetch starts in one of two ways. The first is a read-resource command pulse. The second is a write-one-to-clear of the resource-exhausted status bit. The ring is bounded by a start pointer and an end pointer. Reaching the end pointer sends the position back to the start. Software keeps its own write pointer into the ring. When the read position catches up with that write pointer, the block raises a sticky exhaustion flag, which tells software to refill descriptors.

Memory is reached through a simple request/response port with one request in flight at a time. The 32-bit fetch address is the upper-address register in bits 31..16 joined to the 16-bit read pointer in bits 15..0. Descriptor words sit 2 bytes apart in narrow (16-bit) mode and 4 bytes apart in wide (32-bit) mode. In both modes the response carries the word's 16 significant bits.

Top module: `rxres_ring_fetcher`

## Requirements
- R1: Out of reset, rdPtr, bufAddr, bufWords, exhausted, cmdFlag, busy and memReq are all 0.
- R2: A fetch issues exactly four one-cycle requests, one at a time; the next request waits until the previous response has arrived. Request k (k = 0..3) carries the address {upperAddr, rdPtr} + k*2 when wideMode=0, or + k*4 when wideMode=1, computed as a 32-bit sum.
- R3: Response k is stored in a fixed place: k=0 in bufAddr[15:0], k=1 in bufAddr[31:16], k=2 in bufWords[15:0], k=3 in bufWords[31:16].
- R4: When the fourth word is captured, rdPtr advances by 8 (wideMode=0) or 16 (wideMode=1), modulo 2^16.
- R5: If the advanced pointer equals ringEnd, rdPtr takes ringStart instead.
- R6: exhausted becomes 1 when the pointer left by a fetch equals ringWrPtr. Once set, it stays set until it is cleared.
- R7: An exhClr pulse clears exhausted on the next clock edge and starts a fetch. It does not set cmdFlag.
- R8: cmdFlag rises on the edge that samples cmdFetch. It falls on the edge that captures the final word of the last fetch, provided no further fetch is queued.
- R9: A trigger (cmdFetch or exhClr) arriving while busy is remembered one deep. The next fetch begins on the edge that completes the current one, and busy does not drop between the two.
- R10: busy rises on the edge that samples a trigger while idle and falls on the edge that captures the fourth word. With a response latency of L cycles, that is 4*(L+1) edges after the trigger edge.
- R11: ptrLoad copies ptrLoadVal into rdPtr when idle. While busy, ptrLoad is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdFetch | input | 1 | Read-resource command pulse |
| exhClr | input | 1 | Write-one-to-clear of exhaustion; also starts a fetch |
| wideMode | input | 1 | 0: 16-bit descriptor layout, 1: 32-bit layout |
| ringStart | input | 16 | Ring start pointer |
| ringEnd | input | 16 | Ring end pointer |
| ringWrPtr | input | 16 | Software write pointer |
| upperAddr | input | 16 | Upper 16 bits of descriptor addresses |
| ptrLoad | input | 1 | Load strobe for the read pointer |
| ptrLoadVal | input | 16 | Value loaded into the read pointer |
| memReq | output | 1 | One-cycle memory read request |
| memAddr | output | 32 | Byte address of the requested word |
| memRspValid | input | 1 | Response strobe |
| memRspData | input | 16 | Response word |
| rdPtr | output | 16 | Current read pointer |
| bufAddr | output | 32 | Current buffer address |
| bufWords | output | 32 | Current buffer word count |
| exhausted | output | 1 | Resource-exhausted status |
| cmdFlag | output | 1 | Read-resource command in progress |
| busy | output | 1 | Fetch in progress |

## Verification
The trigger-side results appear on the edge that samples the trigger: cmdFlag and busy rise, and exhausted clears for an exhClr. The descriptor outputs, the new pointer and the exhaustion flag are due exactly 4*(L+1) edges later, and a queued second fetch finishes 8*(L+1) edges after the first trigger. The bench drives inputs on falling edges and counts falling edges from the trigger. It samples 1 ns after a falling edge, one cycle before the due edge (busy still high) and just after it. The memory model checks every request address as it is issued, using a pointer that the bench advances on its own. The sweep covers latencies 1 to 3, both layouts, a ring that crosses the 16-bit pointer overflow, and a ring placed mid-range.

// File: rtl/rxres_pkg.sv
package rxres_pkg;
  // descriptor layout: address low, address high, count low, count high
  localparam int DESC_WORDS = 4;
  localparam int IDX_W      = $clog2(DESC_WORDS);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } fsmState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             capture;   // response word valid this cycle
    logic [IDX_W-1:0] idx;       // descriptor word being fetched
    logic             advance;   // last word captured, step the ring
    logic             loadPtr;   // software pointer load accepted
    logic             clearExh;  // exhaustion write-one-to-clear
  } strobe_t;
endpackage

// File: rtl/rxres_ctrl.sv
module rxres_ctrl
  import rxres_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdFetch,
  input  logic    exhClr,
  input  logic    ptrLoad,
  input  logic    memRspValid,
  output logic    memReq,
  output logic    busy,
  output logic    cmdFlag,
  output strobe_t strobe
);
  fsmState_t        state;
  logic [IDX_W-1:0] idx;
  logic             queued;
  logic             cmdFlagQ;
  logic             trigger;
  logic             lastWord;

  assign trigger  = cmdFetch | exhClr;
  assign lastWord = (state == ST_WAIT) && memRspValid &&
                    (idx == IDX_W'(DESC_WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      idx      <= '0;
      queued   <= 1'b0;
      cmdFlagQ <= 1'b0;
    end else begin
      if (cmdFetch)
        cmdFlagQ <= 1'b1;
      else if (lastWord && !queued)
        cmdFlagQ <= 1'b0;

      case (state)
        ST_IDLE: begin
          if (trigger) begin
            state <= ST_REQ;
            idx   <= '0;
          end
        end
        ST_REQ: state <= ST_WAIT;
        ST_WAIT: begin
          if (memRspValid) begin
            if (lastWord) begin
              if (queued || trigger) begin
                state <= ST_REQ;
                idx   <= '0;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_REQ;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase

      if (lastWord)
        queued <= 1'b0;
      else if (state != ST_IDLE && trigger)
        queued <= 1'b1;
    end
  end

  assign memReq  = (state == ST_REQ);
  assign busy    = (state != ST_IDLE);
  assign cmdFlag = cmdFlagQ;

  always_comb begin
    strobe.capture  = (state == ST_WAIT) && memRspValid;
    strobe.idx      = idx;
    strobe.advance  = lastWord;
    strobe.loadPtr  = ptrLoad && (state == ST_IDLE);
    strobe.clearExh = exhClr;
  end
endmodule

// File: rtl/rxres_dpath.sv
module rxres_dpath
  import rxres_pkg::*;
#(
  parameter int PTR_W   = 16,
  parameter int UPPER_W = 16,
  parameter int WORD_W  = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strobe,
  input  logic                       wideMode,
  input  logic [PTR_W-1:0]           ringStart,
  input  logic [PTR_W-1:0]           ringEnd,
  input  logic [PTR_W-1:0]           ringWrPtr,
  input  logic [UPPER_W-1:0]         upperAddr,
  input  logic [PTR_W-1:0]           ptrLoadVal,
  input  logic [WORD_W-1:0]          memRspData,
  output logic [UPPER_W+PTR_W-1:0]   memAddr,
  output logic [PTR_W-1:0]           rdPtr,
  output logic [2*WORD_W-1:0]        bufAddr,
  output logic [2*WORD_W-1:0]        bufWords,
  output logic                       exhausted
);
  localparam int ADDR_W      = UPPER_W + PTR_W;
  localparam int NARROW_STEP = DESC_WORDS * WORD_W / 8;
  localparam int WIDE_STEP   = 2 * NARROW_STEP;

  logic [PTR_W-1:0]  rdPtrQ;
  logic [PTR_W-1:0]  stepSz;
  logic [PTR_W-1:0]  advPtr;
  logic [PTR_W-1:0]  nextPtr;
  logic [IDX_W+1:0]  byteOff;
  logic              exhQ;
  logic [WORD_W-1:0] descWord [DESC_WORDS];

  // word offset inside the descriptor: 2 bytes narrow, 4 bytes wide
  assign byteOff = wideMode ? {strobe.idx, 2'b00} : {1'b0, strobe.idx, 1'b0};
  assign memAddr = {upperAddr, rdPtrQ} + ADDR_W'(byteOff);

  assign stepSz  = wideMode ? PTR_W'(WIDE_STEP) : PTR_W'(NARROW_STEP);
  assign advPtr  = rdPtrQ + stepSz;
  assign nextPtr = (advPtr == ringEnd) ? ringStart : advPtr;

  for (genvar g = 0; g < DESC_WORDS; g++) begin : gen_word
    always_ff @(posedge clk) begin
      if (!rstN)
        descWord[g] <= '0;
      else if (strobe.capture && strobe.idx == IDX_W'(g))
        descWord[g] <= memRspData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtrQ <= '0;
      exhQ   <= 1'b0;
    end else begin
      if (strobe.loadPtr)
        rdPtrQ <= ptrLoadVal;
      else if (strobe.advance)
        rdPtrQ <= nextPtr;

      if (strobe.advance && nextPtr == ringWrPtr)
        exhQ <= 1'b1;
      else if (strobe.clearExh)
        exhQ <= 1'b0;
    end
  end

  assign rdPtr     = rdPtrQ;
  assign exhausted = exhQ;
  assign bufAddr   = {descWord[1], descWord[0]};
  assign bufWords  = {descWord[3], descWord[2]};
endmodule

// File: rtl/rxres_ring_fetcher.sv
module rxres_ring_fetcher
  import rxres_pkg::*;
#(
  parameter int PTR_W   = 16,
  parameter int UPPER_W = 16,
  parameter int WORD_W  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cmdFetch,
  input  logic                     exhClr,
  input  logic                     wideMode,
  input  logic [PTR_W-1:0]         ringStart,
  input  logic [PTR_W-1:0]         ringEnd,
  input  logic [PTR_W-1:0]         ringWrPtr,
  input  logic [UPPER_W-1:0]       upperAddr,
  input  logic                     ptrLoad,
  input  logic [PTR_W-1:0]         ptrLoadVal,
  output logic                     memReq,
  output logic [UPPER_W+PTR_W-1:0] memAddr,
  input  logic                     memRspValid,
  input  logic [WORD_W-1:0]        memRspData,
  output logic [PTR_W-1:0]         rdPtr,
  output logic [2*WORD_W-1:0]      bufAddr,
  output logic [2*WORD_W-1:0]      bufWords,
  output logic                     exhausted,
  output logic                     cmdFlag,
  output logic                     busy
);
  strobe_t strobe;

  rxres_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdFetch   (cmdFetch),
    .exhClr     (exhClr),
    .ptrLoad    (ptrLoad),
    .memRspValid(memRspValid),
    .memReq     (memReq),
    .busy       (busy),
    .cmdFlag    (cmdFlag),
    .strobe     (strobe)
  );

  rxres_dpath #(
    .PTR_W  (PTR_W),
    .UPPER_W(UPPER_W),
    .WORD_W (WORD_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wideMode  (wideMode),
    .ringStart (ringStart),
    .ringEnd   (ringEnd),
    .ringWrPtr (ringWrPtr),
    .upperAddr (upperAddr),
    .ptrLoadVal(ptrLoadVal),
    .memRspData(memRspData),
    .memAddr   (memAddr),
    .rdPtr     (rdPtr),
    .bufAddr   (bufAddr),
    .bufWords  (bufWords),
    .exhausted (exhausted)
  );
endmodule

// File: rtl/rxres_checker.sv
module rxres_checker #(
  parameter int PTR_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdFetch,
  input logic             exhClr,
  input logic             ptrLoad,
  input logic             memReq,
  input logic             busy,
  input logic             cmdFlag,
  input logic             exhausted,
  input logic             advance,
  input logic [PTR_W-1:0] rdPtr,
  input logic [PTR_W-1:0] ringStart,
  input logic [PTR_W-1:0] ringEnd
);
  // R2: requests are single-cycle, never back to back
  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  // R10: a request only appears during a fetch
  assert_req_in_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  // R4: the pointer moves only on a ring step or a load
  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!advance && !ptrLoad) |=> $stable(rdPtr));

  // R5: a step never leaves the pointer sitting on the end bound
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (advance && ringStart != ringEnd) |=> (rdPtr != $past(ringEnd)));

  // R6: exhaustion is raised only by a ring step
  assert_exh_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(exhausted) |-> $past(advance));

  // R8: the command flag is raised only by a command
  assert_cmd_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdFlag) |-> $past(cmdFetch));

  // R10: busy starts only from a trigger
  assert_busy_rise_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdFetch || exhClr));
endmodule

bind rxres_ring_fetcher rxres_checker #(.PTR_W(PTR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdFetch (cmdFetch),
  .exhClr   (exhClr),
  .ptrLoad  (ptrLoad),
  .memReq   (memReq),
  .busy     (busy),
  .cmdFlag  (cmdFlag),
  .exhausted(exhausted),
  .advance  (strobe.advance),
  .rdPtr    (rdPtr),
  .ringStart(ringStart),
  .ringEnd  (ringEnd)
);

// File: tb/rxres_ring_fetcher_tb.sv
`timescale 1ns/1ps
module rxres_ring_fetcher_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdFetch = 1'b0;
  logic        exhClr = 1'b0;
  logic        wideMode = 1'b0;
  logic [15:0] ringStart = '0;
  logic [15:0] ringEnd = '0;
  logic [15:0] ringWrPtr = '0;
  logic [15:0] upperAddr = '0;
  logic        ptrLoad = 1'b0;
  logic [15:0] ptrLoadVal = '0;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memRspValid = 1'b0;
  logic [15:0] memRspData = '0;
  logic [15:0] rdPtr;
  logic [31:0] bufAddr;
  logic [31:0] bufWords;
  logic        exhausted;
  logic        cmdFlag;
  logic        busy;

  int checks = 0;
  int fails  = 0;
  int lat    = 1;

  logic [15:0] refPtr   = '0;
  logic        refExh   = 1'b0;
  logic [15:0] lastBase = '0;
  int          reqIdx   = 0;
  int          rspCnt   = 0;
  logic [31:0] pAddr    = '0;

  always #2 clk = ~clk;

  rxres_ring_fetcher u_dut (
    .clk(clk), .rstN(rstN), .cmdFetch(cmdFetch), .exhClr(exhClr),
    .wideMode(wideMode), .ringStart(ringStart), .ringEnd(ringEnd),
    .ringWrPtr(ringWrPtr), .upperAddr(upperAddr), .ptrLoad(ptrLoad),
    .ptrLoadVal(ptrLoadVal), .memReq(memReq), .memAddr(memAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .rdPtr(rdPtr),
    .bufAddr(bufAddr), .bufWords(bufWords), .exhausted(exhausted),
    .cmdFlag(cmdFlag), .busy(busy)
  );

  function automatic logic [15:0] memFn(input logic [31:0] a);
    logic [15:0] m;
    m = a[15:0] * 16'd40503;
    return m ^ a[31:16] ^ 16'h6C1B;
  endfunction

  function automatic logic [15:0] stepPtr(input logic [15:0] p);
    logic [15:0] a;
    a = p + (wideMode ? 16'd16 : 16'd8);
    return (a == ringEnd) ? ringStart : a;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: one response per request after lat cycles
  always @(negedge clk) begin
    logic [31:0] ea;
    memRspValid = 1'b0;
    if (rstN && memReq) begin
      ea = {upperAddr, refPtr} + 32'(reqIdx * (wideMode ? 4 : 2));
      chk("R2 request address", memAddr, ea);
      chk("R2 single request in flight", 32'(rspCnt), 32'd0);
      if (reqIdx == 0) lastBase = refPtr;
      pAddr  = memAddr;
      rspCnt = lat;
      reqIdx++;
      if (reqIdx == 4) begin
        reqIdx = 0;
        refPtr = stepPtr(refPtr);
        if (refPtr == ringWrPtr) refExh = 1'b1;
      end
    end else if (rspCnt > 0) begin
      rspCnt--;
      if (rspCnt == 0) begin
        memRspValid = 1'b1;
        memRspData  = memFn(pAddr);
      end
    end
  end

  task automatic checkResults(input string when);
    logic [31:0] b;
    int s;
    b = {upperAddr, lastBase};
    s = wideMode ? 4 : 2;
    chk({"R3 bufAddr ", when}, bufAddr, {memFn(b + 32'(s)), memFn(b)});
    chk({"R3 bufWords ", when}, bufWords, {memFn(b + 32'(3*s)), memFn(b + 32'(2*s))});
    chk({"R4/R5 rdPtr ", when}, 32'(rdPtr), 32'(refPtr));
    chk({"R6 exhausted ", when}, 32'(exhausted), 32'(refExh));
  endtask

  task automatic loadPtr(input logic [15:0] v);
    @(negedge clk);
    ptrLoad = 1'b1; ptrLoadVal = v; refPtr = v;
    @(negedge clk);
    ptrLoad = 1'b0;
    #1 chk("R11 pointer load while idle", 32'(rdPtr), 32'(v));
  endtask

  task automatic runFetch(input bit useClr);
    int n;
    n = 4 * (lat + 1);
    @(negedge clk);
    if (useClr) begin exhClr = 1'b1; refExh = 1'b0; end
    else cmdFetch = 1'b1;
    @(negedge clk);
    cmdFetch = 1'b0; exhClr = 1'b0;
    #1;
    chk("R10 busy after trigger", 32'(busy), 32'd1);
    if (useClr) begin
      chk("R7 exhausted cleared", 32'(exhausted), 32'd0);
      chk("R7 cmdFlag untouched", 32'(cmdFlag), 32'd0);
    end else begin
      chk("R8 cmdFlag raised", 32'(cmdFlag), 32'd1);
    end
    repeat (n - 1) @(negedge clk);
    #1 chk("R10 busy before last word", 32'(busy), 32'd1);
    @(negedge clk);
    #1;
    chk("R10 busy after last word", 32'(busy), 32'd0);
    chk("R8 cmdFlag cleared", 32'(cmdFlag), 32'd0);
    checkResults(useClr ? "after clear fetch" : "after command");
  endtask

  task automatic runQueued();
    int n;
    n = 4 * (lat + 1);
    @(negedge clk);
    cmdFetch = 1'b1;
    @(negedge clk);
    cmdFetch = 1'b0;
    repeat (lat + 1) @(negedge clk);
    cmdFetch = 1'b1; ptrLoad = 1'b1; ptrLoadVal = 16'h0BAD;
    @(negedge clk);
    cmdFetch = 1'b0; ptrLoad = 1'b0;
    repeat (n - (lat + 2)) @(negedge clk);
    #1;
    chk("R9 busy held across queued fetch", 32'(busy), 32'd1);
    chk("R8 cmdFlag held while queued", 32'(cmdFlag), 32'd1);
    repeat (n) @(negedge clk);
    #1;
    chk("R9 busy after queued fetch", 32'(busy), 32'd0);
    chk("R8 cmdFlag after queued fetch", 32'(cmdFlag), 32'd0);
    checkResults("after queued fetch, R11 load ignored");
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 rdPtr reset", 32'(rdPtr), 32'd0);
    chk("R1 bufAddr reset", bufAddr, 32'd0);
    chk("R1 bufWords reset", bufWords, 32'd0);
    chk("R1 flags reset", {28'd0, exhausted, cmdFlag, busy, memReq}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    for (int l = 1; l <= 3; l++) begin
      for (int w = 0; w < 2; w++) begin
        logic [15:0] st;
        logic [15:0] s0;
        lat = l;
        wideMode = w[0];
        st = w ? 16'd16 : 16'd8;
        s0 = (l == 2) ? 16'hFFF0 : 16'h0200 + 16'(l) * 16'h0040;
        upperAddr = (l == 2) ? 16'h12FF : 16'h00A5 + 16'(w);
        ringStart = s0;
        ringEnd   = s0 + 16'd3 * st;
        ringWrPtr = s0 + 16'd2 * st;
        loadPtr(s0);
        runFetch(1'b0);
        runFetch(1'b0);
        runFetch(1'b1);
        runFetch(1'b0);
        runQueued();
        runFetch(1'b0);
      end
    end
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule